// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C bus master that software steers one byte at a time through three registers: control, status and data. Each bus event (START, repeated START, an address or data byte with its acknowledge slot, or a lost arbitration) ends by raising an event flag. The same event loads a fixed one-byte code into the status register. While the flag is up, the block holds SCL low, so the bus waits for software. Software looks at the code, loads the data register or changes the control bits, and then writes the flag to zero. That write lets the next action start.

The bus lines are open-drain. Each line has an output-enable pin (1 pulls the wire low) and an input pin that reads the level on the wire. Three control bits select the bit rate, which is a division of the block clock. If a target device stretches SCL, the block waits until SCL is released. A simple byte-wide register port gives access to the block. Writes are taken in the cycle in which select and write-enable are both high. The read data follows the address through combinational logic. There is no back-pressure on this port: every access completes in one cycle.

Top module: `i2cm_top`

## Requirements
- R1: After reset, status reads 0xF8, control and data read 0x00, the interrupt output is low and both line drivers are released.
- R2: Writing control with enable (bit 6) and start-request (bit 5) set, while the event flag (bit 3) is clear, generates a START and reports status 0x08 with the flag set. The interrupt output equals flag AND enable.
- R3: The byte written to data after a START is sent as the address. It holds the 7-bit target in bits 7:1, and bit 0 is 1 for read. The address phase ends with 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) or 0x48 (read, NACK).
- R4: In a write transfer, each data byte goes out MSB first and ends with 0x28 (ACK) or 0x30 (NACK).
- R5: In a read transfer, the received byte is placed in the data register. The master answers with ACK when control bit 2 is set (status 0x50) and with NACK when it is clear (status 0x58).
- R6: A stop-request (control bit 4) taken while the flag is cleared puts a STOP condition on the bus. Stop-request then clears itself, status returns to 0xF8, and the flag stays clear.
- R7: A start-request taken while the block holds the bus after an event produces a repeated START with status 0x10.
- R8: While the flag is set, SCL stays low and the status does not change. Writing 1 to bit 3 neither sets the flag nor clears it. Only writing 0 to bit 3 releases the next action.
- R9: If the block releases SDA for a 1 bit but samples it low, it releases both lines and reports 0x38 with the flag set.
- R10: Clearing enable releases both lines, clears the flag and sets status to 0xF8.
- R11: The rate code {bit 7, bit 1, bit 0} selects a divisor of 256, 224, 192, 160, 960, 120, 60 or 8 for codes 0 to 7. SCL then stays high for divisor/2 clock cycles.
- R12: Register offsets are 0x00 control, 0x04 status, 0x08 data and 0x0C own-address. Data and own-address read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write enable, taken with reg_sel |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Event flag AND enable |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL wire level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA wire level |

## Verification
The bench builds the block with its default ADDR_W of 5 and CNT_W of 8. An 8-bit quarter-period counter covers every rate code up to the 960 divisor, so the bench can switch the rate code at run time. It uses the divide-by-8 code for the protocol tests, which keeps each byte under a hundred cycles. It measures the SCL high time for divisors 8, 60 and 960, which covers both the shortest and the longest quarter period.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_BITS, E_ACK, E_HOLD, E_STOP
  } eng_st_t;

  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_AW_ACK  = 8'h18;
  localparam logic [7:0] SC_AW_NACK = 8'h20;
  localparam logic [7:0] SC_TX_ACK  = 8'h28;
  localparam logic [7:0] SC_TX_NACK = 8'h30;
  localparam logic [7:0] SC_ARB     = 8'h38;
  localparam logic [7:0] SC_AR_ACK  = 8'h40;
  localparam logic [7:0] SC_AR_NACK = 8'h48;
  localparam logic [7:0] SC_RX_ACK  = 8'h50;
  localparam logic [7:0] SC_RX_NACK = 8'h58;
  localparam logic [7:0] SC_NONE    = 8'hF8;

  // control bit positions
  localparam int CB_R0  = 0;
  localparam int CB_R1  = 1;
  localparam int CB_AA  = 2;
  localparam int CB_SI  = 3;
  localparam int CB_STO = 4;
  localparam int CB_STA = 5;
  localparam int CB_ENS = 6;
  localparam int CB_R2  = 7;

  function automatic int unsigned rate_div(input logic [2:0] code);
    case (code)
      3'd0: return 256;
      3'd1: return 224;
      3'd2: return 192;
      3'd3: return 160;
      3'd4: return 960;
      3'd5: return 120;
      3'd6: return 60;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] code,
  output logic       tick
);
  logic [31:0]      quarter;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;

  assign quarter = rate_div(code) >> 2;
  assign lim     = CNT_W'(quarter - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // smallest quarter period is two cycles
  assert_tick_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       si_flag,
  input  logic       req_sta,
  input  logic       req_sto,
  input  logic [7:0] tx_byte,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       done,
  output logic [7:0] done_code,
  output logic       rx_load,
  output logic [7:0] rx_byte,
  output logic       stop_done
);
  eng_st_t    st;
  logic [1:0] q;
  logic [2:0] nbit;
  logic [7:0] sh;
  logic       cur_tx, is_rd, byte_is_addr, addr_next, rep, ack_seen;
  logic       advance, go;

  // a released SCL held low by a target stops the phase counter
  assign advance = tick && !(q == 2'd2 && !scl_in);
  assign go      = (st == E_HOLD) && !si_flag && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_IDLE; q <= '0; nbit <= '0; sh <= '0;
      cur_tx <= 1'b0; is_rd <= 1'b0; byte_is_addr <= 1'b0;
      addr_next <= 1'b0; rep <= 1'b0; ack_seen <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0;
      done <= 1'b0; done_code <= SC_NONE;
      rx_load <= 1'b0; rx_byte <= '0; stop_done <= 1'b0;
    end else begin
      done      <= 1'b0;
      rx_load   <= 1'b0;
      stop_done <= 1'b0;
      if (!en) begin
        st <= E_IDLE; q <= '0; scl_low <= 1'b0; sda_low <= 1'b0;
      end else begin
        case (st)
          E_IDLE: begin
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            q <= '0;
            if (req_sto && !si_flag && !stop_done) begin
              stop_done <= 1'b1;
            end else if (req_sta && !si_flag && !done) begin
              st  <= E_START;
              rep <= 1'b0;
            end
          end
          E_START: if (advance) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              2'd3: begin
                scl_low   <= 1'b1;
                done      <= 1'b1;
                done_code <= rep ? SC_RSTART : SC_START;
                addr_next <= 1'b1;
                st        <= E_HOLD;
              end
            endcase
          end
          E_BITS: if (advance) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_low <= cur_tx & ~sh[7];
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (cur_tx && !sda_low && !sda_in) begin
                  scl_low   <= 1'b0;
                  sda_low   <= 1'b0;
                  done      <= 1'b1;
                  done_code <= SC_ARB;
                  st        <= E_IDLE;
                  q         <= '0;
                end else begin
                  sh <= {sh[6:0], sda_in};
                end
              end
              2'd3: begin
                scl_low <= 1'b1;
                nbit    <= nbit + 3'd1;
                if (nbit == 3'd7) st <= E_ACK;
              end
            endcase
          end
          E_ACK: if (advance) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_low <= cur_tx ? 1'b0 : req_ack();
              2'd1: scl_low <= 1'b0;
              2'd2: ack_seen <= !sda_in;
              2'd3: begin
                scl_low <= 1'b1;
                done    <= 1'b1;
                st      <= E_HOLD;
                if (byte_is_addr) begin
                  if (is_rd) done_code <= ack_seen ? SC_AR_ACK : SC_AR_NACK;
                  else       done_code <= ack_seen ? SC_AW_ACK : SC_AW_NACK;
                end else if (cur_tx) begin
                  done_code <= ack_seen ? SC_TX_ACK : SC_TX_NACK;
                end else begin
                  done_code <= ack_seen ? SC_RX_ACK : SC_RX_NACK;
                  rx_load   <= 1'b1;
                  rx_byte   <= sh;
                end
              end
            endcase
          end
          E_HOLD: begin
            scl_low <= 1'b1;
            if (go) begin
              q <= '0;
              if (req_sto) begin
                st <= E_STOP;
              end else if (req_sta) begin
                st  <= E_START;
                rep <= 1'b1;
              end else begin
                st           <= E_BITS;
                nbit         <= '0;
                byte_is_addr <= addr_next;
                addr_next    <= 1'b0;
                if (addr_next) is_rd <= tx_byte[0];
                cur_tx       <= addr_next | !is_rd;
                sh           <= tx_byte;
              end
            end
          end
          E_STOP: if (advance) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              2'd3: begin
                stop_done <= 1'b1;
                st        <= E_IDLE;
              end
            endcase
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end

  // acknowledge choice comes from the control register through ack_in
  logic ack_in;
  function automatic logic req_ack();
    return ack_in;
  endfunction

  assert_single_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, stop_done}));

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_OWN  = ADDR_W'(12);

  logic [7:0] ctrl_q, ctrl_d, status_q, data_q, own_q;
  logic       wr_ctrl, wr_data, wr_own;
  logic       tick, eng_done, rx_load, stop_done, scl_low, sda_low;
  logic [7:0] eng_code, rx_byte;

  assign wr_ctrl = reg_sel && reg_we && (reg_addr == OFF_CTRL);
  assign wr_data = reg_sel && reg_we && (reg_addr == OFF_DATA);
  assign wr_own  = reg_sel && reg_we && (reg_addr == OFF_OWN);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d        = reg_wdata;
      ctrl_d[CB_SI] = ctrl_q[CB_SI] & reg_wdata[CB_SI];
    end
    if (eng_done)        ctrl_d[CB_SI]  = 1'b1;
    if (stop_done)       ctrl_d[CB_STO] = 1'b0;
    if (!ctrl_d[CB_ENS]) ctrl_d[CB_SI]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= SC_NONE;
      data_q   <= '0;
      own_q    <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (!ctrl_q[CB_ENS])   status_q <= SC_NONE;
      else if (eng_done)     status_q <= eng_code;
      else if (stop_done)    status_q <= SC_NONE;
      if (rx_load)           data_q <= rx_byte;
      else if (wr_data)      data_q <= reg_wdata;
      if (wr_own)            own_q  <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_CTRL: reg_rdata = ctrl_q;
      OFF_STAT: reg_rdata = status_q;
      OFF_DATA: reg_rdata = data_q;
      OFF_OWN:  reg_rdata = own_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq    = ctrl_q[CB_SI] & ctrl_q[CB_ENS];
  assign scl_oe = scl_low;
  assign sda_oe = sda_low;

  i2cm_tick #(.CNT_W(CNT_W)) i_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctrl_q[CB_ENS]),
    .code ({ctrl_q[CB_R2], ctrl_q[CB_R1], ctrl_q[CB_R0]}),
    .tick (tick)
  );

  i2cm_engine i_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_q[CB_ENS]),
    .tick     (tick),
    .si_flag  (ctrl_q[CB_SI]),
    .req_sta  (ctrl_q[CB_STA]),
    .req_sto  (ctrl_q[CB_STO]),
    .tx_byte  (data_q),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_low  (scl_low),
    .sda_low  (sda_low),
    .done     (eng_done),
    .done_code(eng_code),
    .rx_load  (rx_load),
    .rx_byte  (rx_byte),
    .stop_done(stop_done)
  );
  assign i_eng.ack_in = ctrl_q[CB_AA];

  assert_scl_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_ENS] && ctrl_q[CB_SI] && status_q != SC_ARB) |-> scl_oe);

  assert_status_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_ENS] && ctrl_q[CB_SI] && !wr_ctrl) |=> $stable(status_q));

  assert_sto_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !ctrl_q[CB_STO]);

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_ENS] && ctrl_q[CB_SI] && status_q == SC_ARB) |-> (!scl_oe && !sda_oe));

  assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CB_ENS] |=> (!scl_oe && !sda_oe));

endmodule

// File: tb/test_i2cm_top.sv
`timescale 1ns/1ps
module test_i2cm_top;
  localparam int ADDR_W = 5;
  localparam logic [6:0] SLV = 7'h50;
  localparam logic [4:0] A_CTRL = 5'd0, A_STAT = 5'd4, A_DATA = 5'd8, A_OWN = 5'd12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic sl_low = 1'b0, force_low = 1'b0, nack_data = 1'b0;
  wire  scl_bus = ~scl_oe;
  wire  sda_bus = ~(sda_oe | sl_low | force_low);

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  i2cm_top #(.ADDR_W(ADDR_W), .CNT_W(8)) i_i2cm_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_oe(scl_oe), .scl_in(scl_bus), .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  // behavioural target at 7-bit address 0x50
  logic ps = 1'b1, pd = 1'b1, rdm = 1'b0, mack = 1'b0;
  int n = 0, phase = 0, rd_k = 0, rx_cnt = 0, stops = 0;
  logic [7:0] sr = '0;
  logic [7:0] rx_log [8];

  function automatic logic [7:0] sl_byte(input int k);
    return 8'hC5 + 8'(k) * 8'h13;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      sl_low = 1'b0; phase = 0; n = 0;
    end else begin
      if (scl_bus && ps && pd && !sda_bus) begin
        phase = 1; n = 0; sl_low = 1'b0;
      end else if (scl_bus && ps && !pd && sda_bus) begin
        phase = 0; sl_low = 1'b0; stops++;
      end else if (!ps && scl_bus) begin
        n++;
        if (n <= 8 && (phase == 1 || phase == 2)) sr = {sr[6:0], sda_bus};
        if (n == 9 && phase == 3) mack = !sda_bus;
      end else if (ps && !scl_bus) begin
        if (n == 8) begin
          if (phase == 1) begin
            if (sr[7:1] == SLV) begin sl_low = 1'b1; rdm = sr[0]; end
            else phase = 0;
          end else if (phase == 2) begin
            if (rx_cnt < 8) rx_log[rx_cnt] = sr;
            rx_cnt++;
            sl_low = !nack_data;
          end else if (phase == 3) sl_low = 1'b0;
        end else if (n == 9) begin
          n = 0; sl_low = 1'b0;
          if (phase == 1) begin
            phase = rdm ? 3 : 2;
            if (rdm) begin rd_k = 0; sr = sl_byte(rd_k); sl_low = !sr[7]; end
            else rx_cnt = 0;
          end else if (phase == 3) begin
            if (mack) begin rd_k++; sr = sl_byte(rd_k); sl_low = !sr[7]; end
            else phase = 0;
          end
        end else if (phase == 3 && n >= 1 && n <= 7) sl_low = !sr[7-n];
      end
      ps = scl_bus; pd = sda_bus;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int t = 0;
    while (!irq && t < 30000) begin @(negedge clk); t++; end
    chk({req, " irq"}, int'(irq), 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // vector: ctrl, data, write data?, expected status, check data?, expected data
  localparam int NV = 9;
  localparam logic [33:0] VEC [NV] = '{
    {8'hE3, 8'h00, 1'b0, 8'h08, 1'b0, 8'h00},  // R2 start
    {8'hC3, 8'hA0, 1'b1, 8'h18, 1'b0, 8'h00},  // R3 write address acked
    {8'hC3, 8'h5E, 1'b1, 8'h28, 1'b0, 8'h00},  // R4 data acked
    {8'hC3, 8'h81, 1'b1, 8'h28, 1'b0, 8'h00},  // R4 data acked
    {8'hE3, 8'h00, 1'b0, 8'h10, 1'b0, 8'h00},  // R7 repeated start
    {8'hC7, 8'hA1, 1'b1, 8'h40, 1'b0, 8'h00},  // R3 read address acked
    {8'hC7, 8'h00, 1'b0, 8'h50, 1'b1, 8'hC5},  // R5 byte acked
    {8'hC3, 8'h00, 1'b0, 8'h58, 1'b1, 8'hD8},  // R5 byte nacked
    {8'hD3, 8'h00, 1'b0, 8'hF8, 1'b0, 8'h00}   // R6 stop
  };
  localparam int VTAG [NV] = '{2, 3, 4, 4, 7, 3, 5, 5, 6};

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] rd;
    int s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_STAT, rd); chk("R1 status", rd, 8'hF8);
    bus_rd(A_CTRL, rd); chk("R1 ctrl", rd, 8'h00);
    bus_rd(A_DATA, rd); chk("R1 data", rd, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    // R12 register map
    bus_wr(A_OWN, 8'h5A);  bus_rd(A_OWN, rd);  chk("R12 own", rd, 8'h5A);
    bus_wr(A_DATA, 8'h3C); bus_rd(A_DATA, rd); chk("R12 data", rd, 8'h3C);

    // table walk: write, repeated start, read, stop
    s0 = stops;
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      if (v[17]) bus_wr(A_DATA, v[25:18]);
      bus_wr(A_CTRL, v[33:26]);
      if (v[16:9] == 8'hF8) begin
        repeat (300) @(negedge clk);
        chk($sformatf("R%0d irq", VTAG[i]), irq, 0);
      end else wait_irq($sformatf("R%0d", VTAG[i]));
      bus_rd(A_STAT, rd); chk($sformatf("R%0d status v%0d", VTAG[i], i), rd, v[16:9]);
      if (v[8]) begin
        bus_rd(A_DATA, rd); chk($sformatf("R%0d rx data", VTAG[i]), rd, v[7:0]);
      end
    end
    bus_rd(A_CTRL, rd); chk("R6 stop bit cleared", rd[4], 0);
    chk("R6 stop on bus", stops - s0, 1);
    chk("R6 lines", {scl_oe, sda_oe}, 0);
    chk("R4 byte0 on bus", rx_log[0], 8'h5E);
    chk("R4 byte1 on bus", rx_log[1], 8'h81);

    // R3 address NACK, then R8 hold behaviour
    bus_wr(A_CTRL, 8'hE3); wait_irq("R2");
    bus_wr(A_DATA, 8'h22); bus_wr(A_CTRL, 8'hC3); wait_irq("R3");
    bus_rd(A_STAT, rd); chk("R3 write nack", rd, 8'h20);
    repeat (400) @(negedge clk);
    bus_rd(A_STAT, rd); chk("R8 status held", rd, 8'h20);
    chk("R8 scl low", scl_oe, 1);
    bus_wr(A_CTRL, 8'hCB);
    repeat (200) @(negedge clk);
    chk("R8 write one keeps flag", irq, 1);
    bus_rd(A_STAT, rd); chk("R8 no progress", rd, 8'h20);
    bus_wr(A_CTRL, 8'hD3); repeat (200) @(negedge clk);
    bus_rd(A_STAT, rd); chk("R6 after nack", rd, 8'hF8);

    // R4 data NACK
    nack_data = 1'b1;
    bus_wr(A_CTRL, 8'hE3); wait_irq("R2");
    bus_wr(A_DATA, 8'hA0); bus_wr(A_CTRL, 8'hC3); wait_irq("R3");
    bus_wr(A_DATA, 8'h77); bus_wr(A_CTRL, 8'hC3); wait_irq("R4");
    bus_rd(A_STAT, rd); chk("R4 data nack", rd, 8'h30);
    bus_wr(A_CTRL, 8'hD3); repeat (200) @(negedge clk);
    nack_data = 1'b0;

    // R3 read address NACK
    bus_wr(A_CTRL, 8'hE3); wait_irq("R2");
    bus_wr(A_DATA, 8'hA3); bus_wr(A_CTRL, 8'hC3); wait_irq("R3");
    bus_rd(A_STAT, rd); chk("R3 read nack", rd, 8'h48);
    bus_wr(A_CTRL, 8'hD3); repeat (200) @(negedge clk);

    // R9 arbitration loss on the first address bit
    bus_wr(A_CTRL, 8'hE3); wait_irq("R2");
    force_low = 1'b1;
    bus_wr(A_DATA, 8'hA0); bus_wr(A_CTRL, 8'hC3); wait_irq("R9");
    bus_rd(A_STAT, rd); chk("R9 status", rd, 8'h38);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    force_low = 1'b0;
    bus_wr(A_CTRL, 8'hC3); repeat (50) @(negedge clk);

    // R10 disable resets the core mid transfer
    bus_wr(A_CTRL, 8'hE3); wait_irq("R2");
    chk("R10 scl held before", scl_oe, 1);
    bus_wr(A_CTRL, 8'h03); @(negedge clk);
    bus_rd(A_STAT, rd); chk("R10 status", rd, 8'hF8);
    chk("R10 irq", irq, 0);
    chk("R10 lines", {scl_oe, sda_oe}, 0);
    bus_rd(A_CTRL, rd); chk("R10 flag", rd[3], 0);
    bus_wr(A_CTRL, 8'h10); bus_wr(A_CTRL, 8'h00); repeat (20) @(negedge clk);

    // R11 SCL high time per rate code
    for (int r = 0; r < 3; r++) begin
      logic [2:0] code;
      logic [7:0] cb;
      int hi, t, exp;
      code = (r == 0) ? 3'd7 : (r == 1) ? 3'd6 : 3'd4;
      exp  = (r == 0) ? 4 : (r == 1) ? 30 : 480;
      cb   = {code[2], 5'b10000, code[1], code[0]} | 8'h40;
      bus_wr(A_CTRL, cb | 8'h20); wait_irq("R11");
      bus_wr(A_DATA, 8'hA0); bus_wr(A_CTRL, cb);
      t = 0;
      while (!scl_bus && t < 5000) begin @(negedge clk); t++; end
      hi = 0;
      while (scl_bus && hi < 5000) begin @(negedge clk); hi++; end
      chk($sformatf("R11 high time code %0d", code), hi, exp);
      wait_irq("R11");
      bus_rd(A_STAT, rd); chk("R11 address ack", rd, 8'h18);
      bus_wr(A_CTRL, cb | 8'h10); repeat (2500) @(negedge clk);
    end

    summary();
  end

endmodule